// File: doc/BRIEF.md
# Nested Vectored Interrupt Entry Sequencer

This block sits next to a small 16-bit processor core and carries out the entry into the extended interrupt mode. A request arrives as a 3-bit binary level code. In every idle cycle the block compares that code with the per-level enable bits of the core's master status word. When it accepts a request, it takes the device's 16-bit reason code in the same cycle. It then writes the return address, the status word and the reason code to a dedicated system stack. Last, it fetches a fresh status word and program counter from a vector table in memory.

Every memory access uses a request/acknowledge handshake, and the memory may insert any number of wait cycles. When the new program counter has arrived, a one-cycle completion pulse tells the core to load the new PC, status word and system stack pointer. Acceptance depends only on the status word the core holds at that moment. A handler whose loaded status word enables other levels can therefore be interrupted by those levels, and interrupts nest on the system stack.

Top module: `irq_entry_seq`

## Requirements
- R1: A level code of 0 is no request: no intAck and no memory request follow it.
- R2: A nonzero code n is accepted (intAck high in that idle cycle) only when bit n of coreMsr is set. Bits 1 to 7 enable levels 1 to 7. Bit 0 and bits 8 to 15 have no effect on acceptance.
- R3: Acceptance uses only the current coreMsr. After an entry loads a status word that enables another level, a request at that level is taken, and its frame is pushed below the previous frame.
- R4: The three pushes are writes (memWe=1) in this order: the PC to sysSp-2, coreMsr to sysSp-4, the reason code to sysSp-6. newSp equals sysSp-6.
- R5: The reason code that is pushed is the value on vecIn in the cycle in which intAck is high.
- R6: After the pushes, two reads (memWe=0) fetch the status word at tableBase+4n and then the PC at tableBase+4n+2.
- R7: An access holds memReq, memAddr, memWe and memWdata stable until memAck is seen, whatever the wait length.
- R8: entryDone is high for exactly one cycle, the cycle after the PC read is acknowledged. In that cycle newPc, newMsr and newSp carry the table words and the lowered stack pointer.
- R9: Requests that arrive while an entry is in progress are ignored: no intAck is given, and the reason code already taken is not changed.
- R10: After reset, memReq, entryDone and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqCode | input | 3 | Encoded request level, 0 = none |
| vecIn | input | 16 | Reason code from the interrupting device |
| intAck | output | 1 | Request accepted this cycle, reason code taken |
| corePc | input | 16 | Core's return address |
| coreMsr | input | 16 | Core's master status word |
| sysSp | input | 16 | Current system stack pointer |
| tableBase | input | 16 | Vector table base address |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Byte address of the word |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| busy | output | 1 | Entry sequence in progress |
| entryDone | output | 1 | One-cycle pulse: new context ready |
| newPc | output | 16 | Handler program counter |
| newMsr | output | 16 | Handler status word |
| newSp | output | 16 | System stack pointer after the pushes |

## Verification
Random status words mix set and clear enable bits with noise in the unused bits. A design that tested the wrong bit, or let code 0 through, would start bus traffic where none is expected. The memory model adds random wait states, so a sequencer that stepped its stack pointer or advanced its state without memAck would write to the wrong stack slots. A directed nesting case sets up a handler whose status word enables a single higher level. It then checks that a lower level is refused and the higher one is taken, with its frame pushed below the first. Requests that arrive in the middle of a sequence, carrying a different reason code, show whether a design re-accepts or overwrites the reason code it already took.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_MSR,
    ST_PUSH_RSN,
    ST_RD_MSR,
    ST_RD_PC,
    ST_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    SEL_PC,
    SEL_MSR,
    SEL_RSN,
    SEL_TMSR,
    SEL_TPC
  } addrSel_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic     capture;   // latch context at acceptance
    logic     spStep;    // push acknowledged, lower stack pointer
    logic     takeMsr;   // table status word arrived
    logic     takePc;    // table PC arrived
    addrSel_t sel;       // which word the memory port carries
  } dpCtl_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LVL_W-1:0]      irqCode,
  input  logic [(1<<LVL_W)-1:0] levelEn,
  input  logic                  memAck,
  output dpCtl_t                ctl,
  output logic                  memReq,
  output logic                  memWe,
  output logic                  busy,
  output logic                  entryDone,
  output logic                  intAck
);

  seqState_t state, stateNext;
  logic accept;

  assign accept    = (state == ST_IDLE) && levelEn[irqCode];
  assign intAck    = accept;
  assign busy      = (state != ST_IDLE);
  assign entryDone = (state == ST_DONE);
  assign memWe     = (state == ST_PUSH_PC) || (state == ST_PUSH_MSR) ||
                     (state == ST_PUSH_RSN);
  assign memReq    = memWe || (state == ST_RD_MSR) || (state == ST_RD_PC);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:     if (accept) stateNext = ST_PUSH_PC;
      ST_PUSH_PC:  if (memAck) stateNext = ST_PUSH_MSR;
      ST_PUSH_MSR: if (memAck) stateNext = ST_PUSH_RSN;
      ST_PUSH_RSN: if (memAck) stateNext = ST_RD_MSR;
      ST_RD_MSR:   if (memAck) stateNext = ST_RD_PC;
      ST_RD_PC:    if (memAck) stateNext = ST_DONE;
      ST_DONE:     stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.capture = accept;
    ctl.spStep  = memWe && memAck;
    ctl.takeMsr = (state == ST_RD_MSR) && memAck;
    ctl.takePc  = (state == ST_RD_PC) && memAck;
    case (state)
      ST_PUSH_MSR: ctl.sel = SEL_MSR;
      ST_PUSH_RSN: ctl.sel = SEL_RSN;
      ST_RD_MSR:   ctl.sel = SEL_TMSR;
      ST_RD_PC:    ctl.sel = SEL_TPC;
      default:     ctl.sel = SEL_PC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8: completion is a single-cycle pulse with the bus idle after it
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |=> !entryDone && !memReq);

  // R4: an accepted request starts with a write access
  p_ack_starts_push_r4: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> memReq && memWe && busy);

  // R9: no acceptance while a sequence is running
  p_busy_no_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !entryDone) |=> !intAck);

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [LVL_W-1:0] irqCode,
  input  logic [DW-1:0]    vecIn,
  input  logic [DW-1:0]    corePc,
  input  logic [DW-1:0]    coreMsr,
  input  logic [DW-1:0]    sysSp,
  input  logic [DW-1:0]    tableBase,
  input  logic [DW-1:0]    memRdata,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic [DW-1:0]    newPc,
  output logic [DW-1:0]    newMsr,
  output logic [DW-1:0]    newSp
);

  localparam logic [DW-1:0] WORD_BYTES = DW'(DW / 8);
  localparam int            ENTRY_SH   = $clog2(2 * (DW / 8));

  logic [DW-1:0]    savedPc, savedMsr, savedRsn, spReg, tblReg;
  logic [LVL_W-1:0] lvlReg;
  logic [DW-1:0]    entryAddr, pushAddr;

  assign pushAddr  = spReg - WORD_BYTES;
  assign entryAddr = tblReg + (DW'(lvlReg) << ENTRY_SH);
  assign newSp     = spReg;

  always_comb begin
    memAddr  = pushAddr;
    memWdata = '0;
    case (ctl.sel)
      SEL_PC:   memWdata = savedPc;
      SEL_MSR:  memWdata = savedMsr;
      SEL_RSN:  memWdata = savedRsn;
      SEL_TMSR: memAddr  = entryAddr;
      SEL_TPC:  memAddr  = entryAddr + WORD_BYTES;
      default:  memWdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc  <= '0;
      savedMsr <= '0;
      savedRsn <= '0;
      spReg    <= '0;
      tblReg   <= '0;
      lvlReg   <= '0;
      newPc    <= '0;
      newMsr   <= '0;
    end else begin
      if (ctl.capture) begin
        savedPc  <= corePc;
        savedMsr <= coreMsr;
        savedRsn <= vecIn;
        spReg    <= sysSp;
        tblReg   <= tableBase;
        lvlReg   <= irqCode;
      end
      if (ctl.spStep)  spReg  <= spReg - WORD_BYTES;
      if (ctl.takeMsr) newMsr <= memRdata;
      if (ctl.takePc)  newPc  <= memRdata;
    end
  end

  // R5: the taken reason code is held for the whole sequence
  p_rsn_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(savedRsn));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int DW     = 16,
  parameter int LVL_W  = 3,
  parameter int EN_LSB = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] irqCode,
  input  logic [DW-1:0]    vecIn,
  output logic             intAck,
  input  logic [DW-1:0]    corePc,
  input  logic [DW-1:0]    coreMsr,
  input  logic [DW-1:0]    sysSp,
  input  logic [DW-1:0]    tableBase,
  output logic             memReq,
  output logic             memWe,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic [DW-1:0]    memRdata,
  input  logic             memAck,
  output logic             busy,
  output logic             entryDone,
  output logic [DW-1:0]    newPc,
  output logic [DW-1:0]    newMsr,
  output logic [DW-1:0]    newSp
);

  localparam int NUM_CODES = 1 << LVL_W;

  logic [NUM_CODES-1:0] levelEn;
  dpCtl_t ctl;

  assign levelEn[0] = 1'b0;
  for (genvar g = 1; g < NUM_CODES; g++) begin : g_lvl_en
    assign levelEn[g] = coreMsr[EN_LSB + g - 1];
  end

  irq_entry_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .irqCode(irqCode), .levelEn(levelEn),
    .memAck(memAck), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .busy(busy), .entryDone(entryDone), .intAck(intAck)
  );

  irq_entry_dp #(.DW(DW), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .irqCode(irqCode), .vecIn(vecIn),
    .corePc(corePc), .coreMsr(coreMsr), .sysSp(sysSp),
    .tableBase(tableBase), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .newPc(newPc), .newMsr(newMsr), .newSp(newSp)
  );

  // R7: a pending access is held until acknowledged
  p_hold_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memAddr) && $stable(memWe)
                            && $stable(memWdata));

  // R4: first push writes the return address just below the stack pointer
  p_first_push_r4: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> (memWdata == $past(corePc)) &&
               (memAddr == $past(sysSp) - DW'(2)));

  // R1: no bus traffic outside a sequence
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  irqCode = '0;
  logic [15:0] vecIn = '0, corePc = '0, coreMsr = '0, sysSp = '0;
  logic [15:0] tableBase = 16'h0100;
  logic [15:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        intAck, memReq, memWe, busy, entryDone;
  logic [15:0] memAddr, memWdata, newPc, newMsr, newSp;

  int nChecks = 0, nFail = 0, cycle = 0, ackCycle = -10;
  logic [15:0] wrAddr [0:7];
  logic [15:0] wrData [0:7];
  logic [15:0] rdAddr [0:3];
  int wrCnt = 0, rdCnt = 0;
  logic [15:0] tblMsr [0:7];
  logic [15:0] tblPc  [0:7];

  always #5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  irq_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .irqCode(irqCode), .vecIn(vecIn),
    .intAck(intAck), .corePc(corePc), .coreMsr(coreMsr), .sysSp(sysSp),
    .tableBase(tableBase), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck), .busy(busy), .entryDone(entryDone), .newPc(newPc),
    .newMsr(newMsr), .newSp(newSp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks, nFail);
    $finish;
  endtask

  function automatic logic [15:0] readModel(input logic [15:0] a);
    logic [15:0] off;
    off = a - tableBase;
    return off[1] ? tblPc[off[4:2]] : tblMsr[off[4:2]];
  endfunction

  // Memory responder with random wait states
  initial begin
    int waitCnt;
    waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (waitCnt == 0) begin
          memAck = 1'b1;
          waitCnt = int'($urandom % 4);
          if (memWe) begin
            wrAddr[wrCnt] = memAddr;
            wrData[wrCnt] = memWdata;
            if (wrCnt < 7) wrCnt++;
          end else begin
            rdAddr[rdCnt] = memAddr;
            memRdata = readModel(memAddr);
            if (rdCnt < 3) rdCnt++;
            if (rdCnt == 2) ackCycle = cycle;
          end
        end else waitCnt--;
      end
    end
  end

  // One request attempt; expected acceptance from R1/R2
  task automatic runEntry(input logic [2:0] code, input logic [15:0] vec,
                          input bit interfere);
    bit expAcc, gotDone, ackDuring;
    logic [15:0] pPc, pMsr, pSp;
    int lvl;
    @(negedge clk);
    irqCode = code; vecIn = vec; wrCnt = 0; rdCnt = 0;
    lvl = int'(code);
    expAcc = (code != 0) && coreMsr[lvl];
    pPc = corePc; pMsr = coreMsr; pSp = sysSp;
    #1;
    if (code == 0) chk(intAck == 1'b0, "R1 intAck", 32'(intAck), 0);
    else chk(intAck == expAcc, "R2 accept", 32'(intAck), 32'(expAcc));
    @(negedge clk);
    if (!expAcc) begin
      chk(memReq == 1'b0 && busy == 1'b0, code == 0 ? "R1 idle" : "R2 idle",
          32'({memReq, busy}), 0);
      irqCode = 0;
      return;
    end
    if (interfere) begin irqCode = 3'd7; vecIn = ~vec; end
    else irqCode = 0;
    gotDone = 0; ackDuring = 0;
    for (int i = 0; i < 100; i++) begin
      if (entryDone) begin gotDone = 1; break; end
      if (intAck) ackDuring = 1;
      @(negedge clk);
    end
    irqCode = 0;
    chk(gotDone, "R8 done seen", 32'(gotDone), 1);
    if (interfere) chk(!ackDuring, "R9 no ack busy", 32'(ackDuring), 0);
    chk(cycle == ackCycle + 1, "R8 timing", cycle, ackCycle + 1);
    chk(wrCnt == 3, "R4 push count", wrCnt, 3);
    chk(wrAddr[0] == pSp - 2 && wrData[0] == pPc, "R4 push pc",
        {wrAddr[0], wrData[0]}, {pSp - 16'd2, pPc});
    chk(wrAddr[1] == pSp - 4 && wrData[1] == pMsr, "R4 push msr",
        {wrAddr[1], wrData[1]}, {pSp - 16'd4, pMsr});
    chk(wrAddr[2] == pSp - 6 && wrData[2] == vec, "R5 R9 push reason",
        {wrAddr[2], wrData[2]}, {pSp - 16'd6, vec});
    chk(rdCnt == 2 && rdAddr[0] == tableBase + 16'(4 * lvl) &&
        rdAddr[1] == tableBase + 16'(4 * lvl + 2), "R6 table reads",
        {rdAddr[0], rdAddr[1]},
        {tableBase + 16'(4 * lvl), tableBase + 16'(4 * lvl + 2)});
    chk(newPc == tblPc[lvl] && newMsr == tblMsr[lvl], "R8 new context",
        {newPc, newMsr}, {tblPc[lvl], tblMsr[lvl]});
    chk(newSp == pSp - 6, "R4 newSp", newSp, pSp - 16'd6);
    corePc = newPc; coreMsr = newMsr; sysSp = newSp;
    @(negedge clk);
    chk(entryDone == 1'b0, "R8 single pulse", 32'(entryDone), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) begin
      tblMsr[i] = 16'h0000; tblPc[i] = 16'(16'h4000 + i * 16);
    end
    repeat (3) @(negedge clk);
    chk(memReq == 0 && entryDone == 0 && busy == 0, "R10 reset",
        32'({memReq, entryDone, busy}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(memReq == 0 && busy == 0, "R10 after release", 32'({memReq, busy}), 0);

    // Directed: code 0 with everything enabled
    coreMsr = 16'hFFFF; corePc = 16'h1234; sysSp = 16'hF000;
    runEntry(3'd0, 16'hAAAA, 0);
    // Directed: enable bit clear, noise bits set (bit 0, upper byte)
    coreMsr = 16'hFF01 | 16'h00F0; // levels 4..7 enabled only
    runEntry(3'd2, 16'h2222, 0);
    // Directed nesting: level 3 handler enables only level 5
    coreMsr = 16'h0008;
    tblMsr[3] = 16'h0020; tblPc[3] = 16'h3300;
    tblMsr[5] = 16'h0000; tblPc[5] = 16'h5500;
    runEntry(3'd3, 16'h0303, 1);   // R9 interference
    runEntry(3'd2, 16'h0202, 0);   // R3: refused inside level-3 handler
    runEntry(3'd5, 16'h0505, 0);   // R3: preempts, frame below
    chk(sysSp == 16'hF000 - 12, "R3 nested frame", sysSp, 16'hF000 - 16'd12);
    runEntry(3'd7, 16'h0707, 0);   // R2: all disabled now

    // Random mix
    for (int k = 0; k < 60; k++) begin
      for (int j = 0; j < 8; j++) begin
        tblMsr[j] = 16'($urandom); tblPc[j] = 16'($urandom);
      end
      coreMsr = 16'($urandom);
      corePc  = 16'($urandom);
      sysSp   = 16'h8000 + 16'(($urandom % 1024) * 2);
      tableBase = 16'h0100 + 16'(($urandom % 16) * 32);
      runEntry(3'($urandom), 16'($urandom), ($urandom % 2) == 1);
    end
    finishRun();
  end

endmodule